// File: doc/BRIEF.md
# UDP/IPv4 Ethernet Frame Header Inserter

This block sits on a wide transmit path and turns a stream of user payload beats into a framed packet. Each packet arrives as 512-bit beats with a per-byte keep mask, a last flag and a 16-bit payload byte count. When the first beat of a packet shows up, the block holds the input back. It emits one beat that carries a complete wire header: line preamble and start delimiter, Ethernet addressing, an IPv4 header and a UDP header. It then opens a pass-through and forwards the payload beats untouched until the last one.

The addresses and ports are elaboration parameters. The IPv4 and UDP length fields come from the byte count sampled when the packet starts. A 16-bit identification counter advances once per packet. The IPv4 header checksum is computed inside the block, and the UDP checksum is sent as zero. Both sides use valid/ready handshakes. While the payload passes through, a stall on the output stalls the source in the same cycle.

Top module: `udp_hdr_inserter`

## Requirements
- R1: After the header beat has been accepted, every payload beat appears on the output with data, keep and last identical to the input, in the same cycle it is presented.
- R2: When in_valid is seen while idle, the header beat is offered with out_valid high from the next cycle. It stays offered with unchanged contents until out_ready is high.
- R3: The identification field (header bytes 26-27) is 0 for the first packet after reset and rises by one for each later packet.
- R4: Header byte k is carried on out_data[511-8k -: 8]. Bytes 0-6 are 0x55 and byte 7 is 0xD5.
- R5: Bytes 8-13 hold the destination MAC, bytes 14-19 the source MAC and bytes 20-21 the EtherType 0x0800.
- R6: IPv4 fixed fields: byte 22 is 0x45, byte 23 is 0x00, bytes 28-29 are 0x4000 (don't-fragment, offset 0), byte 30 is TTL 64, byte 31 is 17, bytes 34-37 are the source IP and bytes 38-41 the destination IP.
- R7: Bytes 24-25 equal byte count + 28 and bytes 46-47 equal byte count + 8, both modulo 2^16. The byte count is taken from in_bytes in the idle cycle where in_valid is first seen. in_bytes in later cycles of the packet has no effect.
- R8: Bytes 32-33 hold the ones'-complement of the end-around-carry sum of the ten 16-bit IPv4 header words, with the checksum word taken as zero.
- R9: Bytes 42-43 hold the source port, bytes 44-45 the destination port and bytes 48-49 are zero.
- R10: The header beat has out_keep[63:14] set, out_keep[13:0] clear and out_last low.
- R11: in_ready is low while idle and while the header beat is pending. During payload pass-through, in_ready equals out_ready and out_valid equals in_valid.
- R12: After an output beat with last is accepted, out_valid is low in the next cycle, and the next packet starts with a fresh header beat.
- R13: While reset is asserted and right after it, out_valid and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Payload beat offered |
| in_ready | output | 1 | Payload beat accepted when high with in_valid |
| in_data | input | 512 | Payload bytes, first byte in the top lane |
| in_keep | input | 64 | Per-byte valid mask of the payload beat |
| in_last | input | 1 | Final beat of the packet |
| in_bytes | input | 16 | Payload byte count, sampled at packet start |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 512 | Header beat or forwarded payload |
| out_keep | output | 64 | Per-byte valid mask of the output beat |
| out_last | output | 1 | Final beat of the framed packet |

## Verification
The header beat is due one clock edge after in_valid is first seen while idle, since only the state register lies in between. It then stays until the edge where out_ready is high. Payload beats and in_ready are combinational, so they are due in the same cycle as the input that causes them. out_valid must drop on the first edge after the last beat is taken. The bench drives every input on the falling edge and compares all outputs 1 ns later against a behavioural model. The model advances its own phase only on the handshakes it has observed, so each expected value is tied to the cycle in which it is due.

// File: rtl/udp_hdr_pkg.sv
package udp_hdr_pkg;

   localparam int LEN_W     = 16;
   localparam int HDR_BYTES = 50;
   localparam int HDR_BITS  = HDR_BYTES * 8;
   localparam int IP_WORDS  = 10;
   localparam int PRE_LEN   = 7;

   localparam logic [7:0]  PRE_BYTE      = 8'h55;
   localparam logic [7:0]  SFD_BYTE      = 8'hD5;
   localparam logic [15:0] ETYPE_IPV4    = 16'h0800;
   localparam logic [7:0]  IP_VER_IHL    = 8'h45;
   localparam logic [7:0]  IP_TOS        = 8'h00;
   localparam logic [7:0]  IP_PROTO_UDP  = 8'd17;
   localparam logic [15:0] IP_FLAGS_FRAG = 16'h4000;
   localparam logic [15:0] IP_HDR_LEN    = 16'd20;
   localparam logic [15:0] UDP_HDR_LEN   = 16'd8;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_PASS = 2'd2
   } ins_state_e;

   // fold a wide sum to 16 bits with end-around carry (two rounds suffice)
   function automatic logic [15:0] oc_fold(input logic [31:0] s);
      logic [31:0] t;
      t = {16'b0, s[31:16]} + {16'b0, s[15:0]};
      t = {16'b0, t[31:16]} + {16'b0, t[15:0]};
      return t[15:0];
   endfunction

endpackage

// File: rtl/udp_ip_csum.sv
module udp_ip_csum
   import udp_hdr_pkg::*;
#(
   parameter int N_WORDS = IP_WORDS
)(
   input  logic [N_WORDS*16-1:0] words,
   output logic [15:0]           csum
);

   localparam int ACC_W = 32;

   generate
      if (N_WORDS < 1 || N_WORDS > 1024) begin : g_bad_words
         $error("udp_ip_csum: N_WORDS out of range");
      end
   endgenerate

   logic [ACC_W-1:0] acc [N_WORDS+1];

   assign acc[0] = '0;

   generate
      for (genvar g = 0; g < N_WORDS; g++) begin : g_sum
         assign acc[g+1] = acc[g] + {{(ACC_W-16){1'b0}}, words[(N_WORDS-1-g)*16 +: 16]};
      end
   endgenerate

   assign csum = ~oc_fold(acc[N_WORDS]);

endmodule

// File: rtl/udp_hdr_fields.sv
module udp_hdr_fields
   import udp_hdr_pkg::*;
#(
   parameter logic [47:0] DST_MAC  = 48'h02_11_22_33_44_55,
   parameter logic [47:0] SRC_MAC  = 48'h02_AA_BB_CC_DD_EE,
   parameter logic [31:0] DST_IP   = 32'hC0A8_0002,
   parameter logic [31:0] SRC_IP   = 32'hC0A8_0001,
   parameter logic [15:0] DST_PORT = 16'd6000,
   parameter logic [15:0] SRC_PORT = 16'd5000,
   parameter logic [7:0]  TTL      = 8'd64
)(
   input  logic [LEN_W-1:0]       pay_bytes,
   input  logic [15:0]            ident,
   input  logic [15:0]            csum,
   output logic [HDR_BITS-1:0]    hdr,
   output logic [IP_WORDS*16-1:0] ip_words
);

   localparam int PRE_BITS = PRE_LEN * 8;

   logic [PRE_BITS-1:0] pre_bytes;
   logic [15:0]         ip_tot;
   logic [15:0]         udp_len;
   logic [159:0]        ip_part;
   logic [63:0]         udp_part;

   generate
      for (genvar g = 0; g < PRE_LEN; g++) begin : g_pre
         assign pre_bytes[g*8 +: 8] = PRE_BYTE;
      end
   endgenerate

   assign ip_tot  = pay_bytes + IP_HDR_LEN + UDP_HDR_LEN;
   assign udp_len = pay_bytes + UDP_HDR_LEN;

   // header words as summed: checksum slot forced to zero
   assign ip_words = {IP_VER_IHL, IP_TOS, ip_tot, ident, IP_FLAGS_FRAG,
                      TTL, IP_PROTO_UDP, 16'h0000, SRC_IP, DST_IP};

   assign ip_part  = {IP_VER_IHL, IP_TOS, ip_tot, ident, IP_FLAGS_FRAG,
                      TTL, IP_PROTO_UDP, csum, SRC_IP, DST_IP};

   assign udp_part = {SRC_PORT, DST_PORT, udp_len, 16'h0000};

   assign hdr = {pre_bytes, SFD_BYTE, DST_MAC, SRC_MAC, ETYPE_IPV4, ip_part, udp_part};

endmodule

// File: rtl/udp_hdr_ctrl.sv
module udp_hdr_ctrl
   import udp_hdr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic             out_ready,
   input  logic [LEN_W-1:0] in_bytes,
   output ins_state_e       st,
   output logic             in_ready,
   output logic [LEN_W-1:0] cap_bytes,
   output logic [15:0]      cap_id
);

   logic [15:0] id_cnt;
   logic        start_pkt;

   assign start_pkt = (st == ST_IDLE) && in_valid;
   assign in_ready  = (st == ST_PASS) && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         id_cnt    <= '0;
         cap_bytes <= '0;
         cap_id    <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (in_valid) begin
                  cap_bytes <= in_bytes;
                  cap_id    <= id_cnt;
                  id_cnt    <= id_cnt + 16'd1;
                  st        <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (out_ready) st <= ST_PASS;
            end
            ST_PASS: begin
               if (in_valid && out_ready && in_last) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_id_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_pkt |=> (id_cnt == $past(id_cnt) + 16'd1));

   assert_id_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !start_pkt |=> $stable(id_cnt));

   assert_cap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |=> ($stable(cap_bytes) && $stable(cap_id)));

endmodule

// File: rtl/udp_hdr_inserter.sv
module udp_hdr_inserter
   import udp_hdr_pkg::*;
#(
   parameter int          DATA_W   = 512,
   parameter logic [47:0] DST_MAC  = 48'h02_11_22_33_44_55,
   parameter logic [47:0] SRC_MAC  = 48'h02_AA_BB_CC_DD_EE,
   parameter logic [31:0] DST_IP   = 32'hC0A8_0002,
   parameter logic [31:0] SRC_IP   = 32'hC0A8_0001,
   parameter logic [15:0] DST_PORT = 16'd6000,
   parameter logic [15:0] SRC_PORT = 16'd5000,
   parameter logic [7:0]  TTL      = 8'd64
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [DATA_W-1:0]   in_data,
   input  logic [DATA_W/8-1:0] in_keep,
   input  logic                in_last,
   input  logic [LEN_W-1:0]    in_bytes,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [DATA_W-1:0]   out_data,
   output logic [DATA_W/8-1:0] out_keep,
   output logic                out_last
);

   localparam int KEEP_W    = DATA_W / 8;
   localparam int PAD_BITS  = DATA_W - HDR_BITS;
   localparam int PAD_BYTES = PAD_BITS / 8;
   localparam int IP_MSB    = DATA_W - 1 - 22 * 8;

   generate
      if ((DATA_W % 8) != 0 || DATA_W < HDR_BITS) begin : g_bad_width
         $error("udp_hdr_inserter: DATA_W must be a byte multiple of at least 400");
      end
   endgenerate

   ins_state_e               st;
   logic [LEN_W-1:0]         cap_bytes;
   logic [15:0]              cap_id;
   logic [15:0]              csum;
   logic [HDR_BITS-1:0]      hdr;
   logic [IP_WORDS*16-1:0]   ip_words;
   logic [DATA_W-1:0]        hdr_beat;
   logic [KEEP_W-1:0]        hdr_keep;
   logic                     hdr_phase;
   logic                     pass_phase;

   udp_hdr_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .out_ready (out_ready),
      .in_bytes  (in_bytes),
      .st        (st),
      .in_ready  (in_ready),
      .cap_bytes (cap_bytes),
      .cap_id    (cap_id)
   );

   udp_hdr_fields #(
      .DST_MAC  (DST_MAC),
      .SRC_MAC  (SRC_MAC),
      .DST_IP   (DST_IP),
      .SRC_IP   (SRC_IP),
      .DST_PORT (DST_PORT),
      .SRC_PORT (SRC_PORT),
      .TTL      (TTL)
   ) u_fields (
      .pay_bytes (cap_bytes),
      .ident     (cap_id),
      .csum      (csum),
      .hdr       (hdr),
      .ip_words  (ip_words)
   );

   udp_ip_csum #(
      .N_WORDS (IP_WORDS)
   ) u_csum (
      .words (ip_words),
      .csum  (csum)
   );

   generate
      if (PAD_BITS > 0) begin : g_pad
         assign hdr_beat = {hdr, {PAD_BITS{1'b0}}};
         assign hdr_keep = {{HDR_BYTES{1'b1}}, {PAD_BYTES{1'b0}}};
      end else begin : g_nopad
         assign hdr_beat = hdr;
         assign hdr_keep = '1;
      end
   endgenerate

   assign hdr_phase  = (st == ST_HDR);
   assign pass_phase = (st == ST_PASS);

   always_comb begin
      if (hdr_phase) begin
         out_valid = 1'b1;
         out_data  = hdr_beat;
         out_keep  = hdr_keep;
         out_last  = 1'b0;
      end else begin
         out_valid = pass_phase && in_valid;
         out_data  = in_data;
         out_keep  = in_keep;
         out_last  = in_last;
      end
   end

   // independent re-sum of the emitted IPv4 header, checksum included
   logic [31:0] vsum;
   always_comb begin
      vsum = '0;
      for (int i = 0; i < IP_WORDS; i++) begin
         vsum = vsum + {16'b0, out_data[IP_MSB - 16*i -: 16]};
      end
   end

   assert_csum_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_phase |-> (oc_fold(vsum) == 16'hFFFF));

   assert_hdr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_phase && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_keep)));

   assert_in_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (out_valid && out_ready));

   assert_end_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid);

endmodule

// File: tb/udp_hdr_inserter_tb.sv
`timescale 1ns/1ps
module udp_hdr_inserter_tb;

   localparam logic [47:0] P_DMAC  = 48'h02_11_22_33_44_55;
   localparam logic [47:0] P_SMAC  = 48'h02_AA_BB_CC_DD_EE;
   localparam logic [31:0] P_DIP   = 32'hC0A8_0002;
   localparam logic [31:0] P_SIP   = 32'hC0A8_0001;
   localparam logic [15:0] P_DPORT = 16'd6000;
   localparam logic [15:0] P_SPORT = 16'd5000;
   localparam logic [63:0] HK      = {{50{1'b1}}, {14{1'b0}}};
   localparam int          NP      = 8;
   localparam int          MAX_CYC = 20000;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid, in_ready, in_last;
   logic [511:0] in_data;
   logic [63:0]  in_keep;
   logic [15:0]  in_bytes;
   logic         out_valid, out_ready, out_last;
   logic [511:0] out_data;
   logic [63:0]  out_keep;

   always #2.5 clk = ~clk;

   udp_hdr_inserter #(
      .DATA_W (512), .DST_MAC (P_DMAC), .SRC_MAC (P_SMAC),
      .DST_IP (P_DIP), .SRC_IP (P_SIP), .DST_PORT (P_DPORT),
      .SRC_PORT (P_SPORT), .TTL (8'd64)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
      .in_keep (in_keep), .in_last (in_last), .in_bytes (in_bytes),
      .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
      .out_keep (out_keep), .out_last (out_last)
   );

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] eb [50];

   int nbeats [NP] = '{1, 3, 1, 2, 1, 4, 1, 2};
   int bcount [NP] = '{64, 150, 18, 100, 65520, 200, 0, 90};

   task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] ob(input int k);
      return out_data[511 - 8*k -: 8];
   endfunction

   task automatic cmp_bytes(input string tag, input int first, input int n);
      logic [127:0] a, e;
      a = '0; e = '0;
      for (int k = 0; k < n; k++) begin
         a = {a[119:0], ob(first + k)};
         e = {e[119:0], eb[first + k]};
      end
      chk(a == e, tag, a, e);
   endtask

   task automatic set_hdr(input logic [15:0] bc, input logic [15:0] id);
      logic [15:0] tl, ul, cs;
      int s;
      tl = bc + 16'd28;
      ul = bc + 16'd8;
      for (int k = 0; k < 7; k++) eb[k] = 8'h55;
      eb[7] = 8'hD5;
      for (int k = 0; k < 6; k++) begin
         eb[8 + k]  = P_DMAC[47 - 8*k -: 8];
         eb[14 + k] = P_SMAC[47 - 8*k -: 8];
      end
      eb[20] = 8'h08; eb[21] = 8'h00; eb[22] = 8'h45; eb[23] = 8'h00;
      eb[24] = tl[15:8]; eb[25] = tl[7:0]; eb[26] = id[15:8]; eb[27] = id[7:0];
      eb[28] = 8'h40; eb[29] = 8'h00; eb[30] = 8'd64; eb[31] = 8'd17;
      eb[32] = 8'h00; eb[33] = 8'h00;
      for (int k = 0; k < 4; k++) begin
         eb[34 + k] = P_SIP[31 - 8*k -: 8];
         eb[38 + k] = P_DIP[31 - 8*k -: 8];
      end
      eb[42] = P_SPORT[15:8]; eb[43] = P_SPORT[7:0];
      eb[44] = P_DPORT[15:8]; eb[45] = P_DPORT[7:0];
      eb[46] = ul[15:8]; eb[47] = ul[7:0]; eb[48] = 8'h00; eb[49] = 8'h00;
      s = 0;
      for (int k = 22; k < 42; k += 2) s = s + int'({eb[k], eb[k + 1]});
      while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
      cs = ~s[15:0];
      eb[32] = cs[15:8]; eb[33] = cs[7:0];
   endtask

   initial begin
      int mph, p, b, cyc, mid, stall_seen;
      logic [15:0] mbc, mcur;
      bit just_ended;
      in_valid = 0; in_last = 0; in_data = '0; in_keep = '0; in_bytes = '0; out_ready = 0;
      rst_n = 0;
      mph = 0; p = 0; b = 0; cyc = 0; mid = 0; mbc = 0; mcur = 0; just_ended = 0; stall_seen = 0;
      repeat (2) @(negedge clk);
      in_valid = 1; out_ready = 1;
      #1;
      chk(!out_valid && !in_ready, "R13 in reset", {out_valid, in_ready}, 0);
      @(negedge clk);
      in_valid = 0;
      rst_n = 1;
      #1;
      chk(!out_valid && !in_ready, "R13 after reset", {out_valid, in_ready}, 0);

      while ((p < NP || mph != 0) && cyc < MAX_CYC) begin
         @(negedge clk);
         cyc++;
         if (p < NP) begin
            in_valid = ($urandom % 10) < 8;
            for (int i = 0; i < 16; i++) in_data[i*32 +: 32] = $urandom;
            in_keep  = {$urandom, $urandom};
            in_last  = (b == nbeats[p] - 1);
            in_bytes = (mph == 0) ? 16'(bcount[p]) : 16'($urandom);
         end else begin
            in_valid = 0; in_last = 0;
         end
         out_ready = ($urandom % 10) < 7;
         #1;
         case (mph)
            0: begin
               chk(!out_valid, just_ended ? "R12 idle after last" : "R11 idle out_valid", out_valid, 0);
               chk(!in_ready, "R11 idle in_ready", in_ready, 0);
               just_ended = 0;
               if (in_valid) begin
                  mbc = in_bytes; mcur = 16'(mid); mid++;
                  set_hdr(mbc, mcur);
                  mph = 1;
               end
            end
            1: begin
               chk(out_valid, stall_seen != 0 ? "R2 header held" : "R2 header offered", out_valid, 1);
               chk(!in_ready, "R11 header in_ready", in_ready, 0);
               cmp_bytes("R4 preamble", 0, 8);
               cmp_bytes("R5 MAC/type", 8, 14);
               cmp_bytes("R6 ver/tos", 22, 2);
               cmp_bytes("R6 flags/ttl/proto", 28, 4);
               cmp_bytes("R6 addresses", 34, 8);
               cmp_bytes("R7 ip length", 24, 2);
               cmp_bytes("R7 udp length", 46, 2);
               cmp_bytes("R3 identification", 26, 2);
               cmp_bytes("R8 checksum", 32, 2);
               cmp_bytes("R9 ports", 42, 4);
               cmp_bytes("R9 udp checksum", 48, 2);
               chk(out_keep == HK && !out_last, "R10 keep/last", {out_keep, out_last}, {HK, 1'b0});
               if (out_ready) begin mph = 2; stall_seen = 0; end
               else stall_seen = 1;
            end
            default: begin
               chk(out_valid == in_valid, "R11 pass out_valid", out_valid, in_valid);
               chk(in_ready == out_ready, "R11 pass in_ready", in_ready, out_ready);
               if (in_valid) begin
                  chk(out_data == in_data, "R1 data", out_data, in_data);
                  chk(out_keep == in_keep && out_last == in_last, "R1 keep/last",
                      {out_keep, out_last}, {in_keep, in_last});
                  if (out_ready) begin
                     if (in_last) begin
                        p++; b = 0; mph = 0; just_ended = 1;
                     end else b++;
                  end
               end
            end
         endcase
      end
      if (cyc >= MAX_CYC) chk(0, "watchdog", cyc, MAX_CYC);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule